// File: doc/BRIEF.md
# Biased Test-Point Enable Generator

This block produces the single global enable that switches the inserted control points of a logic self-test session on and off. When the chip runs in its functional mode the enable stays at 0, so every control point stays transparent and the functional logic sees its own values. In self-test mode the enable is refreshed once per scan pattern from a pseudorandom source.

The enable is deliberately biased towards 1. A 16-bit maximal-length Fibonacci LFSR supplies equiprobable bits, and the block ORs a selectable number k of them, taken from distinct state bits. The probability that the enable is 1 is therefore (2^k-1)/2^k: one half for k=1, 15/16 for k=4, 63/64 for k=6 and 255/256 for k=8. Because the enable is still 0 in a small share of patterns, a stuck-at-1 defect on the enable distribution can be exposed. The surrounding controller raises the self-test mode input for the whole session and pulses the pattern strobe once per scan vector.

Top module: `tpen_gen`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `tp_enable` is 0. Reset loads the LFSR with the seed 16'hACE1, and the first pattern after reset uses the state that follows this seed.
- R2: In every cycle in which `bist_mode` is low, `tp_enable` is 0, whatever `pat_strobe` and `k_sel` do.
- R3: The LFSR moves one step only at a rising clock edge where `bist_mode` and `pat_strobe` are both high, and holds its state otherwise, including across functional-mode stretches. One step shifts the state left by one bit and puts s[15]^s[13]^s[12]^s[10] into bit 0 (polynomial x^16+x^14+x^13+x^11+1).
- R4: At a stepping edge the enable takes the OR of state bits 0, 2, 4, ..., 2(k-1) of the newly stepped state. It is visible on `tp_enable` right after that edge.
- R5: Between stepping edges the enable value is held, and changes on `k_sel` have no effect on it until the next stepping edge.
- R6: `k_sel` sets k. The value 0 acts as 1, the values 1 to 8 act as themselves, and the values 9 to 15 act as 8.
- R7: Over any 65535 consecutive stepping edges at a fixed k, the enable is 1 in exactly 65536-2^(16-k) patterns. For k=6 this is 64512.
- R8: With k=1, the enable is 1 in about half of the patterns: 2048 plus or minus 96 out of 4096 consecutive patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bist_mode | input | 1 | High during a self-test session, low in functional mode |
| pat_strobe | input | 1 | One-cycle pulse per scan pattern; requests a fresh enable |
| k_sel | input | 4 | Number of OR-ed pseudorandom bits (bias setting) |
| tp_enable | output | 1 | Global control-point enable |

## Verification
A new enable value appears on `tp_enable` after the rising edge where the strobe is sampled with `bist_mode` high. The forcing to 0 in functional mode acts in the same cycle that `bist_mode` is low, with no register delay. The bench drives every input at the falling edge and compares at the next falling edge, so each comparison sees the result of exactly one rising edge. The expected value comes from a bench model of the polynomial and tap positions stated above. The counts for R7 and R8 are gathered over one full LFSR period and over a 4096-pattern window.

// File: rtl/tpen_pkg.sv
package tpen_pkg;

    localparam int LFSR_W  = 16;
    localparam int KMAX    = 8;
    localparam int K_W     = $clog2(KMAX + 1);
    localparam int TAP_STRIDE = LFSR_W / KMAX;

    typedef logic [LFSR_W-1:0] lfsr_t;
    typedef logic [K_W-1:0]    ksel_t;

    // feedback taps for x^16 + x^14 + x^13 + x^11 + 1 (state bits 15,13,12,10)
    localparam lfsr_t FB_MASK = 16'hB400;
    localparam lfsr_t SEED    = 16'hACE1;

    typedef struct packed {
        logic  step;
        ksel_t k_eff;
    } tpen_ctl_t;

    function automatic lfsr_t lfsr_adv(input lfsr_t s);
        return {s[LFSR_W-2:0], ^(s & FB_MASK)};
    endfunction

    function automatic int tap_pos(input int idx);
        return idx * TAP_STRIDE;
    endfunction

    function automatic ksel_t clamp_k(input ksel_t k);
        if (k == '0)
            return ksel_t'(1);
        else if (int'(k) > KMAX)
            return ksel_t'(KMAX);
        else
            return k;
    endfunction

endpackage

// File: rtl/tpen_lfsr.sv
module tpen_lfsr
    import tpen_pkg::*;
#(
    parameter lfsr_t INIT = SEED
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    output lfsr_t state_q,
    output lfsr_t state_nxt
);

    assign state_nxt = lfsr_adv(state_q);

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= INIT;
        else if (step)
            state_q <= state_nxt;
    end

    // R3
    lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(state_q));

    // R7
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

endmodule

// File: rtl/tpen_bias_or.sv
module tpen_bias_or
    import tpen_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ksel_t k_raw,
    input  lfsr_t state,
    output logic  or_bit
);

    ksel_t k_eff;
    lfsr_t sel_mask;

    assign k_eff = clamp_k(k_raw);

    genvar gi;
    generate
        for (gi = 0; gi < LFSR_W; gi++) begin : g_mask
            if ((gi % TAP_STRIDE) == 0 && (gi / TAP_STRIDE) < KMAX) begin : g_tap
                assign sel_mask[gi] = (int'(k_eff) > (gi / TAP_STRIDE));
            end else begin : g_off
                assign sel_mask[gi] = 1'b0;
            end
        end
    endgenerate

    assign or_bit = |(state & sel_mask);

    // R6
    mask_width_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(sel_mask) == int'(k_eff));

    // R4
    tap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        sel_mask[tap_pos(0)] == 1'b1);

endmodule

// File: rtl/tpen_gen.sv
module tpen_gen
    import tpen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bist_mode,
    input  logic       pat_strobe,
    input  logic [3:0] k_sel,
    output logic       tp_enable
);

    tpen_ctl_t ctl;
    lfsr_t     lfsr_q;
    lfsr_t     lfsr_nxt;
    logic      or_bit;
    logic      en_q;

    assign ctl.step  = bist_mode & pat_strobe;
    assign ctl.k_eff = ksel_t'(k_sel);

    tpen_lfsr #(.INIT(SEED)) u_lfsr (
        .clk       (clk),
        .rst       (rst),
        .step      (ctl.step),
        .state_q   (lfsr_q),
        .state_nxt (lfsr_nxt)
    );

    tpen_bias_or u_bias (
        .clk    (clk),
        .rst    (rst),
        .k_raw  (ctl.k_eff),
        .state  (lfsr_nxt),
        .or_bit (or_bit)
    );

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else if (ctl.step)
            en_q <= or_bit;
    end

    assign tp_enable = en_q & bist_mode;

    // R5
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl.step |=> $stable(en_q));

    // R4
    en_zero_tap_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ctl.step) && !$past(rst) && !en_q) |-> (lfsr_q[0] == 1'b0));

endmodule

// File: tb/tpen_gen_tb_top.sv
module tpen_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       bist_mode;
    logic       pat_strobe;
    logic [3:0] k_sel;
    logic       tp_enable;

    always #4 clk = ~clk;

    tpen_gen dut_i (
        .clk        (clk),
        .rst        (rst),
        .bist_mode  (bist_mode),
        .pat_strobe (pat_strobe),
        .k_sel      (k_sel),
        .tp_enable  (tp_enable)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          finished = 0;
    logic [15:0] m_st;
    logic        m_en;
    int unsigned seed_v;

    function automatic logic [15:0] m_adv(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic m_or(input logic [15:0] s, input int k);
        int kk;
        logic r;
        kk = (k == 0) ? 1 : ((k > 8) ? 8 : k);
        r = 1'b0;
        for (int i = 0; i < kk; i++) r = r | s[2*i];
        return r;
    endfunction

    task automatic check(input string req, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: tp_enable got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    // drive at falling edge, one rising edge, compare at next falling edge
    task automatic cyc(input string req, input logic bm, input logic st, input int k);
        bist_mode  = bm;
        pat_strobe = st;
        k_sel      = 4'(k);
        @(posedge clk);
        if (bm && st) begin
            m_st = m_adv(m_st);
            m_en = m_or(m_st, k);
        end
        @(negedge clk);
        check(req, tp_enable, bm ? m_en : 1'b0);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int ones;
        seed_v = $urandom(32'h5EED);
        rst = 1'b1; bist_mode = 1'b1; pat_strobe = 1'b1; k_sel = 4'd8;
        m_st = 16'hACE1; m_en = 1'b0;
        repeat (3) @(negedge clk);
        // R1: output low during reset
        check("R1", tp_enable, 1'b0);
        rst = 1'b0;
        pat_strobe = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", tp_enable, 1'b0);
        // R1: first pattern comes from the seed successor
        cyc("R1", 1'b1, 1'b1, 8);

        // R2: functional mode forces 0; R3: LFSR must not move meanwhile
        for (int i = 0; i < 50; i++)
            cyc("R2", 1'b0, 1'($urandom_range(0, 1)), int'($urandom_range(0, 15)));
        cyc("R3", 1'b1, 1'b0, 3);
        cyc("R3", 1'b1, 1'b1, 8);

        // R6: every k_sel code including out-of-range values
        for (int k = 0; k < 16; k++) cyc("R6", 1'b1, 1'b1, k);

        // R5: held between strobes while k_sel changes
        cyc("R5", 1'b1, 1'b1, 1);
        for (int i = 0; i < 8; i++) cyc("R5", 1'b1, 1'b0, i + 8);

        // R4 / R3: random mix of modes, strobes and settings
        for (int i = 0; i < 3000; i++)
            cyc("R4", 1'($urandom_range(0, 4) != 0), 1'($urandom_range(0, 1)),
                int'($urandom_range(0, 15)));

        // R8: k=1 near one half
        ones = 0;
        for (int i = 0; i < 4096; i++) begin
            cyc("R8", 1'b1, 1'b1, 1);
            if (tp_enable === 1'b1) ones++;
        end
        n_cmp++;
        if (ones < 2048 - 96 || ones > 2048 + 96) begin
            n_bad++;
            $display("FAIL R8: ones count got %0d expected 2048 +/- 96", ones);
        end

        // R7: exact count over one full LFSR period at k=6
        ones = 0;
        for (int i = 0; i < 65535; i++) begin
            cyc("R7", 1'b1, 1'b1, 6);
            if (tp_enable === 1'b1) ones++;
        end
        n_cmp++;
        if (ones != 64512) begin
            n_bad++;
            $display("FAIL R7: ones count got %0d expected 64512", ones);
        end

        finished = 1;
        summary();
        $finish;
    end

endmodule